// File: doc/BRIEF.md
# Lane-Partitioned Saturating Adder

This block adds two 64-bit operands. A run-time lane-size select splits the adder into one 64-bit lane, four 16-bit lanes or eight 8-bit lanes. The carry chain is cut at every lane boundary, so each lane adds on its own.

Each lane detects its own overflow. The signed select chooses how overflow is judged: two's-complement sign overflow when signed, carry out of the lane when unsigned. When saturation is enabled, a lane that overflows is clamped to its extreme value. When saturation is off, the lane keeps its wrapped sum. A flag bit per 8-bit segment reports overflow for the lane whose most significant byte sits in that segment.

The adder itself is combinational. The result and the flags are captured in output registers, so the block fits a single pipeline stage.

Top module: `simd_sat_add`

## Requirements
- R1: With lane_sel = 2'b00 the block performs one 64-bit add. With saturation off, the result is (opa + opb) mod 2^64.
- R2: The reserved code lane_sel = 2'b11 gives exactly the same result and flags as 2'b00.
- R3: With lane_sel = 2'b01 each 16-bit lane [16k+15:16k] is added independently, and no carry crosses a 16-bit boundary.
- R4: With lane_sel = 2'b10 each 8-bit lane [8k+7:8k] is added independently, and no carry crosses an 8-bit boundary.
- R5: With sat_en = 1 and sgn_en = 0, a lane whose unsigned sum carries out of the lane becomes all ones.
- R6: With sat_en = 1 and sgn_en = 1, a lane with positive sign overflow becomes its largest positive value (0 then all ones). A lane with negative sign overflow becomes its most negative value (1 then all zeros).
- R7: With sat_en = 0, an overflowing lane keeps its wrapped sum and still raises its flag.
- R8: ovf_q bit i is the overflow of the lane whose top byte is byte i: carry out when sgn_en = 0, sign overflow when sgn_en = 1. In 16-bit mode only the odd bits can be set. In 64-bit mode only bit 7 can be set. Every other bit reads 0.
- R9: Results appear on sum_q and ovf_q at the first rising clock edge after the inputs are applied. A synchronous active-high rst clears both outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opa | input | 64 | First operand |
| opb | input | 64 | Second operand |
| lane_sel | input | 2 | Lane size: 00 = 64-bit, 01 = 16-bit, 10 = 8-bit, 11 = 64-bit |
| sat_en | input | 1 | Clamp overflowing lanes instead of wrapping |
| sgn_en | input | 1 | Treat lanes as two's-complement signed |
| sum_q | output | 64 | Registered lane results |
| ovf_q | output | 8 | Registered per-lane overflow flags |

## Verification
Both the sum and the flags are due exactly one rising edge after the operands and controls are applied. The bench therefore drives every input on a falling edge and compares one nanosecond after the next rising edge. One directed check samples just before that rising edge to confirm that the outputs still show the previous result. Random operands are built byte by byte from boundary values (00, 7F, 80, FF) mixed with random bytes, so that overflow occurs often in every lane size.

// File: rtl/simd_add_pkg.sv
package simd_add_pkg;

    localparam int DATA_W   = 64;
    localparam int SEG_W    = 8;
    localparam int NSEG     = DATA_W / SEG_W;
    localparam int MID_W    = 16;
    localparam int MID_SEGS = MID_W / SEG_W;

    typedef enum logic [1:0] {
        LANE_64  = 2'b00,
        LANE_16  = 2'b01,
        LANE_8   = 2'b10,
        LANE_RSV = 2'b11
    } lane_sel_e;

    typedef struct packed {
        logic [SEG_W-1:0] sum;
        logic             cout;
        logic             msb_cin;
    } seg_sum_t;

    // Marks the segments that hold the most significant byte of a lane.
    function automatic logic [NSEG-1:0] lane_top_mask(lane_sel_e m);
        logic [NSEG-1:0] k;
        for (int i = 0; i < NSEG; i++) begin
            case (m)
                LANE_8:  k[i] = 1'b1;
                LANE_16: k[i] = ((i % MID_SEGS) == (MID_SEGS - 1));
                default: k[i] = (i == NSEG - 1);
            endcase
        end
        return k;
    endfunction

    // Index of the top segment of the lane that contains segment i.
    function automatic int lane_top_of(int i, lane_sel_e m);
        case (m)
            LANE_8:  return i;
            LANE_16: return i - (i % MID_SEGS) + MID_SEGS - 1;
            default: return NSEG - 1;
        endcase
    endfunction

endpackage

// File: rtl/simd_seg_add.sv
module simd_seg_add
    import simd_add_pkg::*;
(
    input  logic [SEG_W-1:0] a,
    input  logic [SEG_W-1:0] b,
    input  logic             cin,
    output seg_sum_t         res
);
    logic [SEG_W:0] s;

    always_comb begin
        s           = {1'b0, a} + {1'b0, b} + {{SEG_W{1'b0}}, cin};
        res.sum     = s[SEG_W-1:0];
        res.cout    = s[SEG_W];
        res.msb_cin = a[SEG_W-1] ^ b[SEG_W-1] ^ s[SEG_W-1];
    end
endmodule

// File: rtl/simd_seg_sat.sv
module simd_seg_sat
    import simd_add_pkg::*;
(
    input  logic [SEG_W-1:0] raw,
    input  logic             lane_ovf,
    input  logic             is_top,
    input  logic             neg_dir,
    input  logic             sat_en,
    input  logic             sgn_en,
    output logic [SEG_W-1:0] out
);
    always_comb begin
        out = raw;
        if (sat_en && lane_ovf) begin
            if (!sgn_en)
                out = '1;
            else if (is_top)
                out = neg_dir ? {1'b1, {(SEG_W-1){1'b0}}} : {1'b0, {(SEG_W-1){1'b1}}};
            else
                out = neg_dir ? '0 : '1;
        end
    end
endmodule

// File: rtl/simd_sat_add.sv
module simd_sat_add
    import simd_add_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic [1:0]        lane_sel,
    input  logic              sat_en,
    input  logic              sgn_en,
    output logic [DATA_W-1:0] sum_q,
    output logic [NSEG-1:0]   ovf_q
);
    lane_sel_e         mode;
    logic [NSEG-1:0]   top_mask;
    logic [NSEG-1:0]   cin;
    logic [NSEG-1:0]   seg_ovf;
    logic [NSEG-1:0]   lane_ovf;
    logic [NSEG-1:0]   lane_neg;
    logic [NSEG-1:0]   flags_d;
    logic [DATA_W-1:0] res_d;
    seg_sum_t          seg [NSEG];

    assign mode     = lane_sel_e'(lane_sel);
    assign top_mask = lane_top_mask(mode);

    generate
        for (genvar i = 0; i < NSEG; i++) begin : g_seg
            if (i == 0) begin : g_first
                assign cin[i] = 1'b0;
            end else begin : g_chain
                // carry is cut where the previous segment ends a lane
                assign cin[i] = top_mask[i-1] ? 1'b0 : seg[i-1].cout;
            end

            simd_seg_add u_add (
                .a   (opa[i*SEG_W +: SEG_W]),
                .b   (opb[i*SEG_W +: SEG_W]),
                .cin (cin[i]),
                .res (seg[i])
            );

            assign seg_ovf[i] = sgn_en ? (seg[i].cout ^ seg[i].msb_cin) : seg[i].cout;

            simd_seg_sat u_sat (
                .raw      (seg[i].sum),
                .lane_ovf (lane_ovf[i]),
                .is_top   (top_mask[i]),
                .neg_dir  (lane_neg[i]),
                .sat_en   (sat_en),
                .sgn_en   (sgn_en),
                .out      (res_d[i*SEG_W +: SEG_W])
            );
        end
    endgenerate

    always_comb begin
        for (int i = 0; i < NSEG; i++) begin
            lane_ovf[i] = seg_ovf[lane_top_of(i, mode)];
            lane_neg[i] = opa[lane_top_of(i, mode)*SEG_W + SEG_W - 1];
        end
    end

    assign flags_d = seg_ovf & top_mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_q <= '0;
            ovf_q <= '0;
        end else begin
            sum_q <= res_d;
            ovf_q <= flags_d;
        end
    end

    // R1: full-width wrap add
    p_full_wrap_r1: assert property (@(posedge clk) disable iff (rst)
        (lane_sel == 2'b00 && !sat_en) |-> (res_d == opa + opb));

    // R4: independent byte lanes
    p_byte_lane_r4: assert property (@(posedge clk) disable iff (rst)
        (lane_sel == 2'b10 && !sat_en) |-> (res_d[15:8] == opa[15:8] + opb[15:8]));

    // R5: unsigned clamp
    p_usat_r5: assert property (@(posedge clk) disable iff (rst)
        (lane_sel == 2'b10 && sat_en && !sgn_en && flags_d[0]) |-> (res_d[7:0] == 8'hFF));

    // R6: signed clamp
    p_ssat_r6: assert property (@(posedge clk) disable iff (rst)
        (lane_sel == 2'b01 && sat_en && sgn_en && flags_d[1])
        |-> (res_d[15:0] == 16'h7FFF || res_d[15:0] == 16'h8000));

    // R8: flags outside lane tops stay low
    p_unused_flags_r8: assert property (@(posedge clk) disable iff (rst)
        (lane_sel == 2'b01) |-> ((flags_d & 8'h55) == 8'h00));

    p_full_flags_r8: assert property (@(posedge clk) disable iff (rst)
        (lane_sel == 2'b00 || lane_sel == 2'b11) |-> (flags_d[6:0] == 7'h00));
endmodule

// File: tb/sim_simd_sat_add.sv
`timescale 1ns/1ps
module sim_simd_sat_add;
    logic        clk = 1'b0;
    logic        rst;
    logic [63:0] opa, opb;
    logic [1:0]  lane_sel;
    logic        sat_en, sgn_en;
    logic [63:0] sum_q;
    logic [7:0]  ovf_q;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    simd_sat_add u0 (
        .clk(clk), .rst(rst), .opa(opa), .opb(opb), .lane_sel(lane_sel),
        .sat_en(sat_en), .sgn_en(sgn_en), .sum_q(sum_q), .ovf_q(ovf_q)
    );

    function automatic void model(input logic [63:0] a, input logic [63:0] b,
                                  input logic [1:0] m, input logic sat, input logic sgn,
                                  output logic [63:0] r, output logic [7:0] f);
        int w;
        int n;
        w = (m == 2'b01) ? 16 : (m == 2'b10) ? 8 : 64;
        n = 64 / w;
        r = '0;
        f = '0;
        for (int l = 0; l < n; l++) begin
            logic [64:0] la, lb, s;
            logic ov, sa;
            la = '0;
            lb = '0;
            for (int k = 0; k < w; k++) begin
                la[k] = a[l*w+k];
                lb[k] = b[l*w+k];
            end
            s  = la + lb;
            sa = la[w-1];
            if (sgn) ov = (la[w-1] == lb[w-1]) && (s[w-1] != sa);
            else     ov = s[w];
            if (sat && ov) begin
                for (int k = 0; k < w; k++) begin
                    if (!sgn)            s[k] = 1'b1;
                    else if (k == w - 1) s[k] = sa;
                    else                 s[k] = ~sa;
                end
            end
            for (int k = 0; k < w; k++) r[l*w+k] = s[k];
            f[l*(w/8) + (w/8) - 1] = ov;
        end
    endfunction

    function automatic string tag_of(input logic [1:0] m, input logic sat, input logic sgn);
        if (sat) return sgn ? "R6" : "R5";
        case (m)
            2'b01:   return "R3";
            2'b10:   return "R4";
            2'b11:   return "R2";
            default: return "R1";
        endcase
    endfunction

    task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s sum actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s flags actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run(input logic [63:0] a, input logic [63:0] b, input logic [1:0] m,
                       input logic sat, input logic sgn, input string req);
        logic [63:0] er;
        logic [7:0]  ef;
        model(a, b, m, sat, sgn, er, ef);
        @(negedge clk);
        opa = a; opb = b; lane_sel = m; sat_en = sat; sgn_en = sgn;
        @(posedge clk);
        #1;
        check64(req, sum_q, er);
        check8("R8", ovf_q, ef);
    endtask

    function automatic logic [63:0] rand_op();
        logic [63:0] v;
        for (int i = 0; i < 8; i++) begin
            case ($urandom % 6)
                0: v[i*8 +: 8] = 8'hFF;
                1: v[i*8 +: 8] = 8'h7F;
                2: v[i*8 +: 8] = 8'h80;
                3: v[i*8 +: 8] = 8'h00;
                default: v[i*8 +: 8] = 8'($urandom);
            endcase
        end
        return v;
    endfunction

    initial begin
        void'($urandom(32'h5EED));
        rst = 1'b1;
        opa = 64'hFFFF_FFFF_FFFF_FFFF; opb = 64'h1; lane_sel = 2'b10;
        sat_en = 1'b1; sgn_en = 1'b0;
        @(posedge clk);
        @(posedge clk);
        #1;
        check64("R9", sum_q, 64'h0);
        check8("R9", ovf_q, 8'h0);
        @(negedge clk);
        rst = 1'b0;

        run(64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 2'b00, 1'b0, 1'b0, "R1");
        check64("R1", sum_q, 64'h0);
        check8("R7", ovf_q, 8'h80);
        run(64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 2'b11, 1'b0, 1'b0, "R2");
        check8("R2", ovf_q, 8'h80);
        run(64'h7FFF_FFFF_FFFF_FFFF, 64'h1, 2'b11, 1'b1, 1'b1, "R2");
        check64("R2", sum_q, 64'h7FFF_FFFF_FFFF_FFFF);
        run(64'h0000_FFFF_0000_FFFF, 64'h0000_0001_0000_0001, 2'b01, 1'b0, 1'b0, "R3");
        check64("R3", sum_q, 64'h0);
        check8("R8", ovf_q, 8'h22);
        run(64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001, 2'b10, 1'b0, 1'b0, "R4");
        check64("R4", sum_q, 64'h0);
        run(64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101, 2'b10, 1'b1, 1'b0, "R5");
        check64("R5", sum_q, 64'hFFFF_FFFF_FFFF_FFFF);
        run(64'h7FFF_8000_7FFF_8000, 64'h0001_FFFF_0001_FFFF, 2'b01, 1'b1, 1'b1, "R6");
        check64("R6", sum_q, 64'h7FFF_8000_7FFF_8000);
        run(64'h7F7F_7F7F_7F7F_7F7F, 64'h0101_0101_0101_0101, 2'b10, 1'b0, 1'b1, "R7");
        check64("R7", sum_q, 64'h8080_8080_8080_8080);
        check8("R7", ovf_q, 8'hFF);

        // R9: outputs hold until the next rising edge
        @(negedge clk);
        opa = 64'h1; opb = 64'h1; lane_sel = 2'b00; sat_en = 1'b0; sgn_en = 1'b0;
        #1;
        check64("R9", sum_q, 64'h8080_8080_8080_8080);
        @(posedge clk);
        #1;
        check64("R9", sum_q, 64'h2);

        for (int i = 0; i < 400; i++) begin
            logic [1:0] m;
            logic s, g;
            m = 2'($urandom);
            s = 1'($urandom);
            g = 1'($urandom);
            run(rand_op(), rand_op(), m, s, g, tag_of(m, s, g));
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end
endmodule